// File: doc/BRIEF.md
# PCI Host Configuration Address Decoder

This block sits between a CPU bus and the configuration side of a PCI host bridge. It accepts one CPU access at a time, decides which decoded range the access hits, and turns the hit into a configuration request on a simple downstream port, a local answer, or an interrupt-acknowledge cycle. Two routes lead to configuration space. The first is an index register and a data register in I/O space, both byte-reversed (big-endian) with respect to the CPU bus. The second is a 4 MiB little-endian memory window. In that window a single set bit among offset bits 11 to 21 selects the target device, and that bit is priority-encoded into a device number.

A one-byte read of a fixed memory address fetches an interrupt vector from the interrupt controller. Level interrupts from the PCI slots are folded onto four host lines. Configuration accesses to the bridge's own function (bus 0, device 0, function 0) are answered from a small read-only header inside the block. Accesses that hit no decoded range complete without acknowledge and read as all ones.

Top module: `cfgdec_top`

## Requirements
- R1: After reset cpu_done, cfg_valid, iack_req and host_irq are low. Every accepted access (cpu_req high while idle) is answered by cpu_done high for exactly one cycle. An access that is answered locally completes on the first falling edge after the accepting rising edge.
- R2: In the memory window (0x80800000 to 0x80BFFFFF), the device number is the position of the lowest set bit among offset bits 11..21, counted from 0 at bit 11. A request goes out on cfg_addr[15:11] with bus 0 in cfg_addr[23:16].
- R3: If none of window offset bits 11..21 is set, the device number is 11.
- R4: Window requests keep offset bits 10:2 in cfg_addr[10:2], with cfg_addr[1:0]=0. cfg_wdata equals cpu_wdata unchanged (little-endian). cfg_be is the lane mask shifted left by cpu_addr[1:0], where the mask for cpu_size 0, 1 and 2 is 0001, 0011 and 1111 respectively.
- R5: The index register sits at I/O dword 0xCF8. A write stores the byte-reversed CPU data, one byte per enabled lane, with lane i going to lane 3-i. A read returns it byte-reversed again. Its fields are: bit 31 enable, [23:16] bus, [15:11] device, [10:8] function, [7:2] dword.
- R6: A data-port access (I/O dword 0xCFC) with index bit 31 set issues a request with cfg_addr = {index[23:2], 2'b00}. cfg_be is the CPU lane mask mirrored (lane i to lane 3-i). Write and read data are byte-reversed.
- R7: A data-port access with index bit 31 clear issues no request. It completes with cpu_hit=1 and reads 0xFFFFFFFF.
- R8: A one-byte read of memory address 0xBFFFFFF0 raises iack_req until iack_valid. It returns {24'h0, iack_vector}.
- R9: A read of more than one byte at 0xBFFFFFF0 raises no iack_req. It completes with cpu_err=1 and reads 0xFFFFFFFF.
- R10: An access that hits no range (including writes to 0xBFFFFFF0) issues no request. It completes with cpu_hit=0 and reads 0xFFFFFFFF.
- R11: Configuration reads of bus 0 / device 0 / function 0 are answered locally with no request. Dword 0 = {DEVICE_ID, VENDOR_ID}, dword 2 = {class code 0x060000, revision 0}, dword 3 = 0x00001008 (cache line 0x08, latency 0x10), dword 13 (capabilities pointer) = 0. Writes to it are dropped.
- R12: pci_int_lvl[4*s+p] is pin p (0..3) of the device numbered FIRST_DEV+s. It drives host_irq[(p + device) & 1]. host_irq[3:2] stay low.
- R13: A request holds cfg_valid and all its fields stable until cfg_ready. cpu_done follows on the falling edge after the consuming rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_done |
| cpu_io | input | 1 | 1 = I/O space, 0 = memory space |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 32 | Byte address |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_wdata | input | 32 | Write data, lane-aligned |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_hit | output | 1 | Access hit a decoded range |
| cpu_err | output | 1 | Invalid-size interrupt-acknowledge access |
| cpu_rdata | output | 32 | Read data |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 24 | {bus, device, function, dword, 2'b00} |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ready | input | 1 | Downstream accepts / completes request |
| cfg_rdata | input | 32 | Configuration read data |
| iack_req | output | 1 | Interrupt-acknowledge request |
| iack_valid | input | 1 | Vector available |
| iack_vector | input | 8 | Interrupt vector |
| pci_int_lvl | input | NUM_SLOTS*4 | Slot interrupt pin levels |
| host_irq | output | 4 | Host interrupt lines |

## Verification
The bench builds the block with its default parameters: a 22-bit window, eleven select bits, and four slots numbered from device 1. Every select position is therefore reachable, including the highest (bit 21), the empty case and a two-bit case. The slot numbers start at 1, so both swizzle parities occur for several pins. Downstream latency is varied from zero to several cycles, which exercises the hold-until-ready path and the stall of the CPU response.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_IACK, ST_RESP} cfgdec_st_t;

  // Enabled byte lanes for a CPU access of the given size at the given offset
  function automatic logic [3:0] lane_mask(logic [1:0] size, logic [1:0] ofs);
    logic [3:0] m;
    case (size)
      2'd0:    m = 4'b0001;
      2'd1:    m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m << ofs;
  endfunction

  function automatic logic [31:0] swap32(logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = x[(3-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [3:0] rev4(logic [3:0] x);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = x[3-i];
    return r;
  endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfgdec_win_xlate.sv
module cfgdec_win_xlate #(
  parameter int WIN_LG = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_LG-3:0] off_dw,
  output logic [4:0]        dev_num,
  output logic [23:0]       xl_addr
);
  localparam int LOW = 11;
  localparam int SEL = WIN_LG - LOW;

  function automatic logic [4:0] first_sel(logic [WIN_LG-3:0] o);
    logic [4:0] r;
    r = 5'(SEL);
    for (int i = SEL - 1; i >= 0; i--) if (o[LOW-2+i]) r = 5'(i);
    return r;
  endfunction

  assign dev_num = first_sel(off_dw);
  assign xl_addr = {8'h00, dev_num, off_dw[8:0], 2'b00};

  // R2: a chosen device number points at a set select bit
  a_r2_sel_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dev_num) < SEL) |-> off_dw[LOW-2+int'(dev_num)]);
  // R3: empty select field maps to the count of select bits
  a_r3_none_set: assert property (@(posedge clk) disable iff (!rst_n)
    (off_dw[WIN_LG-3:LOW-2] == '0) |-> (int'(dev_num) == SEL));
endmodule

// File: rtl/cfgdec_own_hdr.sv
module cfgdec_own_hdr #(
  parameter logic [15:0] VENDOR_ID  = 16'h1F0A,
  parameter logic [15:0] DEVICE_ID  = 16'h4801,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h060000
) (
  input  logic [5:0]  dw,
  output logic [31:0] data
);
  always_comb begin
    case (dw)
      6'd0:    data = {DEVICE_ID, VENDOR_ID};
      6'd2:    data = {CLASS_CODE, REV_ID};
      6'd3:    data = {8'h00, 8'h00, 8'h10, 8'h08};
      6'd13:   data = 32'h0;
      default: data = 32'h0;
    endcase
  end
endmodule

// File: rtl/cfgdec_irq_swz.sv
module cfgdec_irq_swz #(
  parameter int NUM_SLOTS = 4,
  parameter int FIRST_DEV = 1
) (
  input  logic [NUM_SLOTS*4-1:0] pin_lvl,
  output logic [3:0]             host_irq
);
  function automatic int route(int pin, int dev);
    return (pin + dev) & 1;
  endfunction

  always_comb begin
    host_irq = 4'b0000;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < 4; p++)
        if (pin_lvl[s*4+p]) host_irq[route(p, FIRST_DEV + s)] = 1'b1;
  end
endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top #(
  parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
  parameter int          WIN_LG     = 22,
  parameter logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0,
  parameter logic [31:0] IDX_PORT   = 32'h0000_0CF8,
  parameter logic [31:0] DAT_PORT   = 32'h0000_0CFC,
  parameter int          NUM_SLOTS  = 4,
  parameter int          FIRST_DEV  = 1,
  parameter logic [15:0] VENDOR_ID  = 16'h1F0A,
  parameter logic [15:0] DEVICE_ID  = 16'h4801
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_io,
  input  logic                   cpu_we,
  input  logic [31:0]            cpu_addr,
  input  logic [1:0]             cpu_size,
  input  logic [31:0]            cpu_wdata,
  output logic                   cpu_done,
  output logic                   cpu_hit,
  output logic                   cpu_err,
  output logic [31:0]            cpu_rdata,
  output logic                   cfg_valid,
  output logic                   cfg_we,
  output logic [23:0]            cfg_addr,
  output logic [3:0]             cfg_be,
  output logic [31:0]            cfg_wdata,
  input  logic                   cfg_ready,
  input  logic [31:0]            cfg_rdata,
  output logic                   iack_req,
  input  logic                   iack_valid,
  input  logic [7:0]             iack_vector,
  input  logic [NUM_SLOTS*4-1:0] pci_int_lvl,
  output logic [3:0]             host_irq
);
  import cfgdec_pkg::*;

  cfgdec_st_t  st;
  logic        r_we, r_swap;
  logic [23:0] r_addr;
  logic [3:0]  r_be;
  logic [31:0] r_wdata, resp_rdata, idx_reg;
  logic        resp_hit, resp_err;

  // decode of the presented access
  logic        win_hit, idx_hit, dat_hit, iack_hit, cfg_go, tgt_own;
  logic [3:0]  cpu_be, tgt_be;
  logic [23:0] xl_addr, tgt_addr;
  logic [31:0] tgt_wd, hdr_data;
  logic [4:0]  dev_num;

  assign win_hit  = !cpu_io && (cpu_addr[31:WIN_LG] == WIN_BASE[31:WIN_LG]);
  assign idx_hit  = cpu_io && (cpu_addr[31:2] == IDX_PORT[31:2]);
  assign dat_hit  = cpu_io && (cpu_addr[31:2] == DAT_PORT[31:2]);
  assign iack_hit = !cpu_io && !cpu_we && (cpu_addr == IACK_ADDR);
  assign cpu_be   = lane_mask(cpu_size, cpu_addr[1:0]);
  assign tgt_addr = win_hit ? xl_addr : {idx_reg[23:2], 2'b00};
  assign tgt_be   = win_hit ? cpu_be : rev4(cpu_be);
  assign tgt_wd   = win_hit ? cpu_wdata : swap32(cpu_wdata);
  assign tgt_own  = (tgt_addr[23:8] == 16'h0);
  assign cfg_go   = win_hit || (dat_hit && idx_reg[31]);

  cfgdec_win_xlate #(.WIN_LG(WIN_LG)) u_xlate (
    .clk(clk), .rst_n(rst_n), .off_dw(cpu_addr[WIN_LG-1:2]),
    .dev_num(dev_num), .xl_addr(xl_addr)
  );

  cfgdec_own_hdr #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_hdr (
    .dw(tgt_addr[7:2]), .data(hdr_data)
  );

  cfgdec_irq_swz #(.NUM_SLOTS(NUM_SLOTS), .FIRST_DEV(FIRST_DEV)) u_swz (
    .pin_lvl(pci_int_lvl), .host_irq(host_irq)
  );

  // named internal events for the checks below
  logic ev_accept, ev_dis, ev_iack_err, ev_unmapped;
  assign ev_accept   = (st == ST_IDLE) && cpu_req;
  assign ev_dis      = ev_accept && dat_hit && !idx_reg[31];
  assign ev_iack_err = ev_accept && iack_hit && (cpu_size != 2'd0);
  assign ev_unmapped = ev_accept && !(win_hit || idx_hit || dat_hit || iack_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      r_we       <= 1'b0;
      r_swap     <= 1'b0;
      r_addr     <= '0;
      r_be       <= '0;
      r_wdata    <= '0;
      resp_rdata <= '0;
      resp_hit   <= 1'b0;
      resp_err   <= 1'b0;
      idx_reg    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cpu_req) begin
          resp_err   <= 1'b0;
          resp_hit   <= 1'b1;
          resp_rdata <= '0;
          r_we       <= cpu_we;
          r_swap     <= !win_hit;
          r_addr     <= tgt_addr;
          r_be       <= tgt_be;
          r_wdata    <= tgt_wd;
          if (cfg_go) begin
            if (tgt_own) begin
              if (!cpu_we) resp_rdata <= win_hit ? hdr_data : swap32(hdr_data);
              st <= ST_RESP;
            end else begin
              st <= ST_CFG;
            end
          end else if (dat_hit) begin
            resp_rdata <= '1;
            st         <= ST_RESP;
          end else if (idx_hit) begin
            if (cpu_we) idx_reg <= lane_merge(idx_reg, swap32(cpu_wdata), rev4(cpu_be));
            else        resp_rdata <= swap32(idx_reg);
            st <= ST_RESP;
          end else if (iack_hit) begin
            if (cpu_size == 2'd0) begin
              st <= ST_IACK;
            end else begin
              resp_err   <= 1'b1;
              resp_rdata <= '1;
              st         <= ST_RESP;
            end
          end else begin
            resp_hit   <= 1'b0;
            resp_rdata <= '1;
            st         <= ST_RESP;
          end
        end
        ST_CFG: if (cfg_ready) begin
          resp_rdata <= r_we ? 32'h0 : (r_swap ? swap32(cfg_rdata) : cfg_rdata);
          st         <= ST_RESP;
        end
        ST_IACK: if (iack_valid) begin
          resp_rdata <= {24'h0, iack_vector};
          st         <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpu_done  = (st == ST_RESP);
  assign cpu_hit   = resp_hit;
  assign cpu_err   = resp_err;
  assign cpu_rdata = resp_rdata;
  assign cfg_valid = (st == ST_CFG);
  assign cfg_we    = r_we;
  assign cfg_addr  = r_addr;
  assign cfg_be    = r_be;
  assign cfg_wdata = r_wdata;
  assign iack_req  = (st == ST_IACK);

  // R1: completion strobe lasts one cycle
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  // R7: disabled data port produces no request and reads all ones
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dis |=> (!cfg_valid && cpu_done && cpu_rdata == 32'hFFFF_FFFF));
  // R8: acknowledge request held until the vector arrives
  a_r8_iack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_req && !iack_valid) |=> iack_req);
  // R9: oversize acknowledge read raises error without an acknowledge
  a_r9_iack_size: assert property (@(posedge clk) disable iff (!rst_n)
    ev_iack_err |=> (!iack_req && cpu_err));
  // R10: unmapped access completes without acknowledge and without side cycles
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unmapped |=> (cpu_done && !cpu_hit && !cfg_valid && !iack_req));
  // R13: request held stable while not ready
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) && $stable(cfg_be)
                                   && $stable(cfg_we) && $stable(cfg_wdata)));
  // R13: response after a downstream cycle only once ready was seen
  a_r13_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && $past(cfg_valid)) |-> $past(cfg_ready));
endmodule

// File: tb/cfgdec_top_tb_top.sv
module cfgdec_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 4;
  localparam int FDEV = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_io = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [1:0] cpu_size = 0;
  logic cpu_done, cpu_hit, cpu_err;
  logic [31:0] cpu_rdata;
  logic cfg_valid, cfg_we;
  logic [23:0] cfg_addr;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata;
  logic cfg_ready = 0;
  logic [31:0] cfg_rdata = 0;
  logic iack_req;
  logic iack_valid = 0;
  logic [7:0] iack_vector = 8'h2F;
  logic [NSLOT*4-1:0] pins = '0;
  logic [3:0] host_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_io(cpu_io), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .cfg_valid(cfg_valid), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
    .iack_req(iack_req), .iack_valid(iack_valid), .iack_vector(iack_vector),
    .pci_int_lvl(pins), .host_irq(host_irq)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] bswap(logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // downstream configuration target model
  logic [31:0] tmem [int];
  int dly = 1, wcnt = 0, stab_err = 0;
  bit busy = 0, cfg_seen = 0, iack_seen = 0;
  logic [23:0] c_addr;
  logic [3:0] c_be;
  logic [31:0] c_wdata;
  logic c_we;

  always @(negedge clk) begin
    if (cfg_valid) begin
      if (!busy) begin
        busy = 1; cfg_seen = 1; wcnt = 0;
        c_addr = cfg_addr; c_be = cfg_be; c_wdata = cfg_wdata; c_we = cfg_we;
      end else if (cfg_addr !== c_addr || cfg_be !== c_be || cfg_wdata !== c_wdata || cfg_we !== c_we) begin
        stab_err++;
      end
      if (wcnt == dly && !cfg_ready) begin
        logic [31:0] cur;
        cur = tmem.exists(int'(c_addr)) ? tmem[int'(c_addr)] : {8'hC0, c_addr};
        if (c_we) begin
          for (int i = 0; i < 4; i++) if (c_be[i]) cur[i*8 +: 8] = c_wdata[i*8 +: 8];
          tmem[int'(c_addr)] = cur;
        end
        cfg_rdata = cur;
        cfg_ready = 1;
      end else if (!cfg_ready) begin
        wcnt++;
      end
    end else begin
      busy = 0; cfg_ready = 0;
    end
  end

  // interrupt controller model
  always @(negedge clk) begin
    if (iack_req) begin iack_valid = 1; iack_seen = 1; end
    else iack_valid = 0;
  end

  // R12: per-clock reference for the interrupt lines
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] e;
      e = 4'b0;
      for (int s = 0; s < NSLOT; s++)
        for (int p = 0; p < 4; p++)
          if (pins[s*4+p]) e[(p + FDEV + s) % 2] = 1'b1;
      nchk++;
      if (host_irq !== e) begin
        nfail++;
        $display("FAIL R12 host_irq actual %h expected %h", host_irq, e);
      end
    end
  end

  logic [31:0] rd;
  logic hit, err;
  int cyc;

  task automatic cpu_op(input logic io, input logic we, input logic [31:0] a,
                        input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    cfg_seen = 0; iack_seen = 0;
    cpu_io = io; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd; cpu_req = 1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 1000);
    rd = cpu_rdata; hit = cpu_hit; err = cpu_err;
    cpu_req = 0;
  endtask

  localparam logic [31:0] WB = 32'h8080_0000;

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", 32'(cpu_done), 0);
    chk("R1 reset cfg_valid", 32'(cfg_valid), 0);
    chk("R1 reset iack_req", 32'(iack_req), 0);
    chk("R1 reset host_irq", 32'(host_irq), 0);
    rst_n = 1;

    // window translation
    dly = 1;
    cpu_op(0, 1, WB | (32'h1 << 14) | 32'h234, 2, 32'hDEADBEEF);
    chk("R2 k3 seen", 32'(cfg_seen), 1);
    chk("R2 k3 addr", 32'(c_addr), 32'h1A34);
    chk("R4 k3 be", 32'(c_be), 32'hF);
    chk("R4 k3 wdata", c_wdata, 32'hDEADBEEF);
    chk("R13 latency d1", cyc, dly + 2);
    cpu_op(0, 0, WB | (32'h1 << 14) | 32'h234, 2, 0);
    chk("R4 readback", rd, 32'hDEADBEEF);
    cpu_op(0, 0, WB | 32'h0020_0010, 2, 0);
    chk("R2 k10 addr", 32'(c_addr), 32'h5010);
    chk("R2 k10 rdata", rd, 32'hC000_5010);
    cpu_op(0, 0, WB | 32'h9000 | 32'h0A, 0, 0);
    chk("R2 lowest of two", 32'(c_addr), 32'h0808);
    chk("R4 byte lane2 be", 32'(c_be), 32'h4);
    cpu_op(0, 0, WB | 32'h7FC, 1, 0);
    chk("R3 none set addr", 32'(c_addr), 32'h5FFC);
    chk("R4 half be", 32'(c_be), 32'h3);
    dly = 0;
    cpu_op(0, 1, WB | 32'h4000 | 32'h102, 1, 32'h1234_0000);
    chk("R4 upper half addr", 32'(c_addr), 32'h1900);
    chk("R4 upper half be", 32'(c_be), 32'hC);
    chk("R13 latency d0", cyc, 2);

    // own header through the window
    cpu_op(0, 0, WB | 32'h80C, 2, 0);
    chk("R11 dw3", rd, 32'h0000_1008);
    chk("R11 no request", 32'(cfg_seen), 0);
    chk("R1 local latency", cyc, 1);
    cpu_op(0, 0, WB | 32'h808, 2, 0);
    chk("R11 class", rd, 32'h0600_0000);
    cpu_op(0, 0, WB | 32'h834, 2, 0);
    chk("R11 cap ptr", rd, 32'h0);
    cpu_op(0, 0, WB | 32'h800, 2, 0);
    chk("R11 ids", rd, 32'h4801_1F0A);
    cpu_op(0, 1, WB | 32'h80C, 2, 32'hFFFF_FFFF);
    chk("R11 write no request", 32'(cfg_seen), 0);
    cpu_op(0, 0, WB | 32'h80C, 2, 0);
    chk("R11 write dropped", rd, 32'h0000_1008);

    // index/data ports
    dly = 2;
    cpu_op(1, 1, 32'hCF8, 2, 32'h1029_0280);
    chk("R5 index write no request", 32'(cfg_seen), 0);
    cpu_op(1, 0, 32'hCF8, 2, 0);
    chk("R5 index readback", rd, 32'h1029_0280);
    cpu_op(1, 0, 32'hCFC, 2, 0);
    chk("R6 addr", 32'(c_addr), 32'h02_2910);
    chk("R6 be", 32'(c_be), 32'hF);
    chk("R6 rdata swapped", rd, bswap(32'hC002_2910));
    cpu_op(1, 1, 32'hCFD, 0, 32'h0000_AB00);
    chk("R6 mirrored be", 32'(c_be), 32'h4);
    chk("R6 wdata lane", 32'(c_wdata[23:16]), 32'hAB);
    cpu_op(1, 1, 32'hCF8, 2, 32'h1029_0200);
    cpu_op(1, 0, 32'hCFC, 2, 0);
    chk("R7 read ones", rd, 32'hFFFF_FFFF);
    chk("R7 hit", 32'(hit), 1);
    chk("R7 no request", 32'(cfg_seen), 0);
    cpu_op(1, 1, 32'hCFC, 2, 32'h5555_5555);
    chk("R7 write no request", 32'(cfg_seen), 0);
    cpu_op(1, 1, 32'hCF8, 0, 32'h0000_0080);
    cpu_op(1, 0, 32'hCF8, 2, 0);
    chk("R5 byte write to enable", rd, 32'h1029_0280);
    cpu_op(1, 1, 32'hCF8, 2, 32'h0C00_0080);
    cpu_op(1, 0, 32'hCFC, 2, 0);
    chk("R11 via port", rd, 32'h0810_0000);
    chk("R11 via port no request", 32'(cfg_seen), 0);

    // interrupt acknowledge
    cpu_op(0, 0, 32'hBFFF_FFF0, 0, 0);
    chk("R8 vector", rd, 32'h0000_002F);
    chk("R8 iack seen", 32'(iack_seen), 1);
    chk("R8 no err", 32'(err), 0);
    chk("R8 latency", cyc, 2);
    cpu_op(0, 0, 32'hBFFF_FFF0, 2, 0);
    chk("R9 err", 32'(err), 1);
    chk("R9 no iack", 32'(iack_seen), 0);
    chk("R9 ones", rd, 32'hFFFF_FFFF);

    // unmapped
    cpu_op(0, 0, 32'h1234_5678, 2, 0);
    chk("R10 mem hit", 32'(hit), 0);
    chk("R10 mem ones", rd, 32'hFFFF_FFFF);
    chk("R10 no request", 32'(cfg_seen), 0);
    chk("R1 unmapped latency", cyc, 1);
    cpu_op(1, 0, 32'h3F8, 2, 0);
    chk("R10 io hit", 32'(hit), 0);
    cpu_op(0, 1, 32'hBFFF_FFF0, 0, 32'h1);
    chk("R10 iack write hit", 32'(hit), 0);
    chk("R10 iack write no iack", 32'(iack_seen), 0);
    cpu_op(0, 0, 32'h807F_FFFC, 2, 0);
    chk("R10 below window", 32'(hit), 0);
    cpu_op(0, 0, 32'h80C0_0000, 2, 0);
    chk("R10 above window", 32'(hit), 0);

    // long downstream stall
    dly = 6;
    cpu_op(0, 0, WB | 32'h1_0000 | 32'h44, 2, 0);
    chk("R13 latency d6", cyc, 8);
    chk("R13 stable fields", stab_err, 0);
    chk("R2 k5 addr", 32'(c_addr), 32'h2844);

    // interrupt swizzle
    @(negedge clk); pins = 16'h0001;
    @(negedge clk); chk("R12 dev1 pinA", 32'(host_irq), 32'h2);
    pins = 16'h0010;
    @(negedge clk); chk("R12 dev2 pinA", 32'(host_irq), 32'h1);
    pins = 16'h0800;
    @(negedge clk); chk("R12 dev3 pinD", 32'(host_irq), 32'h1);
    pins = 16'h0002;
    @(negedge clk); chk("R12 dev1 pinB", 32'(host_irq), 32'h1);
    pins = 16'hFFFF;
    @(negedge clk); chk("R12 all pins", 32'(host_irq), 32'h3);
    pins = 16'h0;
    @(negedge clk); chk("R12 none", 32'(host_irq), 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule